// File: doc/BRIEF.md
# LED Backlight Dimming Ramp and PWM Clock Controller

This block is the digital side of an LED backlight boost stage. Software hands it a 7-bit control word with a write strobe. The word switches the drive on or off, picks how long a full-scale brightness ramp takes, picks the boost operating mode and picks the rate of the PWM dimming clock.

From that word the block produces three things:
- An 8-bit current-level value. It climbs one step at a time toward full scale when the drive is switched on and falls toward zero when it is switched off, so the LEDs never change brightness abruptly.
- A one-cycle PWM clock-enable pulse at one of four rates. The rates are a base rate divided by 1, 2, 3 or 4.
- A one-hot decoded mode, plus a flag that reports an unsupported mode request.

The analog current loop and the switching stage consume these outputs and are not part of this block.

Top module: `led_dim_ctrl`

## Requirements
- R1: While rst_ni is low, level_o is 0, mode_o is 3'b001 (constant-current), mode_illegal_o is 0 and pwm_tick_o is 0.
- R2: The control word is taken only on a clock edge with ctrl_we_i high. Its fields are: bit 0 enable, bits 2:1 ramp-time code, bits 4:3 mode code, bits 6:5 PWM rate code. With ctrl_we_i low, changes on ctrl_i have no effect on any output.
- R3: With enable 1, level_o rises by exactly 1 every L cycles until it reaches 255, and then holds.
- R4: With enable 0, level_o falls by exactly 1 every L cycles until it reaches 0, and then holds.
- R5: The step period is L = max(1, floor(CLK_HZ * T / (1000 * 255))). T is 15, 460, 930 or 1850 ms for ramp-time codes 00, 01, 10 and 11.
- R6: A write that changes the enable bit or the ramp-time code keeps the current level and restarts the step timer. The first step after such a write then lands exactly L cycles after the write edge, in the new direction. level_o never changes by more than 1 between consecutive cycles.
- R7: Mode codes are decoded into one-hot mode_o, registered on the write edge: code 00 gives 3'b001 (constant-current), 01 gives 3'b010 (fixed high-voltage) and 10 gives 3'b100 (PWM boost).
- R8: Writing mode code 11 sets mode_illegal_o and leaves mode_o at its previous value. The next write with a legal mode code clears mode_illegal_o.
- R9: pwm_tick_o is a one-cycle pulse with period P = B * (code + 1), where B = max(2, floor(CLK_HZ / PWM_BASE_HZ)) and code is the PWM rate code.
- R10: A write that changes the PWM rate code restarts the divider. No pulse appears until exactly P_new cycles after the write edge, and pulses repeat every P_new cycles after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctrl_we_i | input | 1 | Control word write strobe |
| ctrl_i | input | 7 | Control word (enable, ramp time, mode, PWM rate) |
| level_o | output | LVL_W | Ramped LED current level |
| pwm_tick_o | output | 1 | PWM dimming clock enable pulse |
| mode_o | output | 3 | One-hot boost mode |
| mode_illegal_o | output | 1 | Unsupported mode code was written |

## Verification
There are three ways a corrupted internal state shows up at the ports:
- A wrong step timer appears as a level_o step that arrives one or more cycles early or late. The bench samples level_o one cycle before each expected step and on the cycle of the step, so an error of a single cycle is visible within one step period.
- A wrong level register shows at once as a jump of more than one count, or as a level that overshoots 255 or 0.
- A stale divider count after a rate change shows as a pulse that arrives before P_new cycles have elapsed.

A wrong held mode shows on mode_o at the first write that follows.

// File: rtl/led_dim_pkg.sv
package led_dim_pkg;

  typedef enum logic [2:0] {
    MODE_CC  = 3'b001,
    MODE_HV  = 3'b010,
    MODE_PWM = 3'b100
  } led_mode_e;

  localparam int unsigned EN_BIT    = 0;
  localparam int unsigned GRAD_LSB  = 1;
  localparam int unsigned MODE_LSB  = 3;
  localparam int unsigned PWMC_LSB  = 5;
  localparam int unsigned CTRL_W    = 7;

  // cycles per level step for a given ramp-time code
  function automatic longint ramp_len(longint clk_hz, logic [1:0] code, longint steps);
    longint ms;
    longint v;
    case (code)
      2'd0:    ms = 15;
      2'd1:    ms = 460;
      2'd2:    ms = 930;
      default: ms = 1850;
    endcase
    v = (clk_hz * ms) / (64'd1000 * steps);
    if (v < 1) v = 1;
    return v;
  endfunction

  function automatic longint pwm_base(longint clk_hz, longint base_hz);
    longint v;
    v = clk_hz / base_hz;
    if (v < 2) v = 2;
    return v;
  endfunction

endpackage

// File: rtl/led_cfg_regs.sv
module led_cfg_regs
  import led_dim_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [CTRL_W-1:0] ctrl_i,
  output logic              en_o,
  output logic [1:0]        grad_o,
  output logic [1:0]        pwmc_o,
  output led_mode_e         mode_o,
  output logic              illegal_o,
  output logic              ramp_restart_o,
  output logic              pwm_restart_o
);

  logic      en_q;
  logic [1:0] grad_q, pwmc_q;
  led_mode_e mode_q;
  logic      illegal_q;

  logic       new_en;
  logic [1:0] new_grad, new_mode, new_pwmc;

  assign new_en   = ctrl_i[EN_BIT];
  assign new_grad = ctrl_i[GRAD_LSB +: 2];
  assign new_mode = ctrl_i[MODE_LSB +: 2];
  assign new_pwmc = ctrl_i[PWMC_LSB +: 2];

  assign ramp_restart_o = we_i && ((new_en != en_q) || (new_grad != grad_q));
  assign pwm_restart_o  = we_i && (new_pwmc != pwmc_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q      <= 1'b0;
      grad_q    <= 2'd0;
      pwmc_q    <= 2'd0;
      mode_q    <= MODE_CC;
      illegal_q <= 1'b0;
    end else if (we_i) begin
      en_q   <= new_en;
      grad_q <= new_grad;
      pwmc_q <= new_pwmc;
      case (new_mode)
        2'b00: begin mode_q <= MODE_CC;  illegal_q <= 1'b0; end
        2'b01: begin mode_q <= MODE_HV;  illegal_q <= 1'b0; end
        2'b10: begin mode_q <= MODE_PWM; illegal_q <= 1'b0; end
        default: illegal_q <= 1'b1;  // unsupported: hold mode
      endcase
    end
  end

  assign en_o      = en_q;
  assign grad_o    = grad_q;
  assign pwmc_o    = pwmc_q;
  assign mode_o    = mode_q;
  assign illegal_o = illegal_q;

endmodule

// File: rtl/led_ramp_gen.sv
module led_ramp_gen
  import led_dim_pkg::*;
#(
  parameter longint      CLK_HZ = 50_000_000,
  parameter int unsigned LVL_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [1:0]       grad_i,
  input  logic             restart_i,
  output logic [LVL_W-1:0] level_o
);

  localparam longint      LVL_MAX = (64'd1 << LVL_W) - 1;
  localparam longint      LEN_MAX = ramp_len(CLK_HZ, 2'd3, LVL_MAX);
  localparam int unsigned CNT_W   = $clog2(LEN_MAX + 1);

  logic [CNT_W-1:0] last_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_len
    localparam longint LEN = ramp_len(CLK_HZ, 2'(g), LVL_MAX);
    assign last_tab[g] = CNT_W'(LEN - 1);
  end

  logic [CNT_W-1:0] cnt_q;
  logic [LVL_W-1:0] lvl_q;
  logic             at_top, at_bot, idle;

  assign at_top = (lvl_q == LVL_W'(LVL_MAX));
  assign at_bot = (lvl_q == '0);
  assign idle   = en_i ? at_top : at_bot;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lvl_q <= '0;
    end else if (restart_i || idle) begin
      cnt_q <= '0;
    end else if (cnt_q >= last_tab[grad_i]) begin
      cnt_q <= '0;
      lvl_q <= en_i ? lvl_q + 1'b1 : lvl_q - 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign level_o = lvl_q;

endmodule

// File: rtl/led_pwm_div.sv
module led_pwm_div
  import led_dim_pkg::*;
#(
  parameter longint CLK_HZ      = 50_000_000,
  parameter longint PWM_BASE_HZ = 8770
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] rate_i,
  input  logic       restart_i,
  output logic       tick_o
);

  localparam longint      BASE  = pwm_base(CLK_HZ, PWM_BASE_HZ);
  localparam int unsigned CNT_W = $clog2(4 * BASE + 1);

  logic [CNT_W-1:0] last_tab [4];

  for (genvar g = 0; g < 4; g++) begin : g_per
    assign last_tab[g] = CNT_W'(BASE * (g + 1) - 1);
  end

  logic [CNT_W-1:0] cnt_q;
  logic             tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (cnt_q >= last_tab[rate_i]) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick_q <= 1'b0;
    end
  end

  assign tick_o = tick_q;

endmodule

// File: rtl/led_dim_ctrl.sv
module led_dim_ctrl
  import led_dim_pkg::*;
#(
  parameter longint      CLK_HZ      = 50_000_000,
  parameter longint      PWM_BASE_HZ = 8770,
  parameter int unsigned LVL_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic [6:0]       ctrl_i,
  output logic [LVL_W-1:0] level_o,
  output logic             pwm_tick_o,
  output logic [2:0]       mode_o,
  output logic             mode_illegal_o
);

  logic       en, ramp_rst, pwm_rst;
  logic [1:0] grad, pwmc;
  led_mode_e  mode;

  led_cfg_regs u_cfg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .we_i           (ctrl_we_i),
    .ctrl_i         (ctrl_i),
    .en_o           (en),
    .grad_o         (grad),
    .pwmc_o         (pwmc),
    .mode_o         (mode),
    .illegal_o      (mode_illegal_o),
    .ramp_restart_o (ramp_rst),
    .pwm_restart_o  (pwm_rst)
  );

  led_ramp_gen #(
    .CLK_HZ (CLK_HZ),
    .LVL_W  (LVL_W)
  ) u_ramp (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (en),
    .grad_i    (grad),
    .restart_i (ramp_rst),
    .level_o   (level_o)
  );

  led_pwm_div #(
    .CLK_HZ      (CLK_HZ),
    .PWM_BASE_HZ (PWM_BASE_HZ)
  ) u_pwm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rate_i    (pwmc),
    .restart_i (pwm_rst),
    .tick_o    (pwm_tick_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/led_dim_chk.sv
module led_dim_chk #(
  parameter int unsigned LVL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ctrl_we_i,
  input logic [6:0]       ctrl_i,
  input logic [LVL_W-1:0] level_o,
  input logic             pwm_tick_o,
  input logic [2:0]       mode_o,
  input logic             mode_illegal_o
);

  logic       en_seen;
  logic [1:0] pwmc_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_seen   <= 1'b0;
      pwmc_seen <= 2'd0;
    end else if (ctrl_we_i) begin
      en_seen   <= ctrl_i[0];
      pwmc_seen <= ctrl_i[6:5];
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r1_reset_state: assert (level_o == '0 && mode_o == 3'b001 &&
                                !mode_illegal_o && !pwm_tick_o);
    end
  end

  a_r6_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (LVL_W'(level_o - $past(level_o)) <= LVL_W'(1)) ||
    (LVL_W'($past(level_o) - level_o) == LVL_W'(1)));

  a_r3_no_fall_when_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_seen |=> level_o >= $past(level_o));

  a_r4_no_rise_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_seen |=> level_o <= $past(level_o));

  a_r7_mode_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mode_o) == 1);

  a_r8_illegal_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i[4:3] == 2'b11) |=> (mode_illegal_o && $stable(mode_o)));

  a_r8_legal_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i[4:3] != 2'b11) |=> !mode_illegal_o);

  a_r9_one_cycle_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pwm_tick_o |=> !pwm_tick_o);

  a_r10_restart_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_we_i && ctrl_i[6:5] != pwmc_seen) |=> !pwm_tick_o);

endmodule

bind led_dim_ctrl led_dim_chk #(.LVL_W(LVL_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ctrl_we_i      (ctrl_we_i),
  .ctrl_i         (ctrl_i),
  .level_o        (level_o),
  .pwm_tick_o     (pwm_tick_o),
  .mode_o         (mode_o),
  .mode_illegal_o (mode_illegal_o)
);

// File: tb/sim_led_dim_ctrl.sv
module sim_led_dim_ctrl;

  localparam longint CLK_HZ  = 100_000;
  localparam longint BASE_HZ = 8770;

  // {ctrl word, expected mode_o, expected mode_illegal_o}
  localparam logic [10:0] VEC [8] = '{
    {7'b0000000, 3'b001, 1'b0},
    {7'b0001000, 3'b010, 1'b0},
    {7'b0011000, 3'b010, 1'b1},
    {7'b0010000, 3'b100, 1'b0},
    {7'b0011000, 3'b100, 1'b1},
    {7'b0011000, 3'b100, 1'b1},
    {7'b0000000, 3'b001, 1'b0},
    {7'b0010000, 3'b100, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       we = 1'b0;
  logic [6:0] ctrl = '0;
  logic [7:0] level;
  logic       tick;
  logic [2:0] mode;
  logic       ill;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  led_dim_ctrl #(
    .CLK_HZ      (CLK_HZ),
    .PWM_BASE_HZ (BASE_HZ),
    .LVL_W       (8)
  ) u0 (
    .clk_i          (clk),
    .rst_ni         (rst_ni),
    .ctrl_we_i      (we),
    .ctrl_i         (ctrl),
    .level_o        (level),
    .pwm_tick_o     (tick),
    .mode_o         (mode),
    .mode_illegal_o (ill)
  );

  function automatic logic [6:0] mk(bit en, bit [1:0] g, bit [1:0] m, bit [1:0] p);
    return {p, m, g, en};
  endfunction

  function automatic int t_len(int code);
    longint ms, v;
    case (code)
      0: ms = 15;
      1: ms = 460;
      2: ms = 930;
      default: ms = 1850;
    endcase
    v = CLK_HZ * ms / 255000;
    return (v < 1) ? 1 : int'(v);
  endfunction

  function automatic int p_len(int code);
    longint b;
    b = CLK_HZ / BASE_HZ;
    if (b < 2) b = 2;
    return int'(b) * (code + 1);
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] v);
    ctrl = v;
    we   = 1'b1;
    @(negedge clk);
    we   = 1'b0;
  endtask

  task automatic skip(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R3 watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int l0, l1, l3, p;
    #2 rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 level", int'(level), 0);
    chk("R1 mode", int'(mode), 1);
    chk("R1 illegal", int'(ill), 0);
    chk("R1 tick", int'(tick), 0);
    rst_ni = 1'b1;

    // R2: no strobe, no effect
    ctrl = mk(1'b1, 2'd0, 2'd3, 2'd2);
    skip(40);
    chk("R2 level", int'(level), 0);
    chk("R2 mode", int'(mode), 1);
    chk("R2 illegal", int'(ill), 0);
    ctrl = '0;

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][10:4]);
      chk("R7 mode vec", int'(mode), int'(VEC[i][3:1]));
      chk("R8 illegal vec", int'(ill), int'(VEC[i][0]));
    end

    // R9, R10: each code differs from the previous one
    for (int k = 0; k < 4; k++) begin
      int c;
      c = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 1 : 0;
      p = p_len(c);
      wr(mk(1'b0, 2'd0, 2'd2, 2'(c)));
      skip(p - 1);
      chk("R10 no early pulse", int'(tick), 0);
      skip(1);
      chk("R10 first pulse", int'(tick), 1);
      skip(1);
      chk("R9 pulse width", int'(tick), 0);
      skip(p - 1);
      chk("R9 period", int'(tick), 1);
    end

    l0 = t_len(0);
    l1 = t_len(1);
    l3 = t_len(3);

    wr(mk(1'b1, 2'd1, 2'd2, 2'd0));
    skip(3 * l1 - 1);
    chk("R5 code01 before step", int'(level), 2);
    skip(1);
    chk("R5 code01 step", int'(level), 3);

    wr(mk(1'b1, 2'd3, 2'd2, 2'd0));
    chk("R6 no jump on code change", int'(level), 3);
    skip(l3 - 1);
    chk("R5 code11 before step", int'(level), 3);
    skip(1);
    chk("R5 code11 step", int'(level), 4);

    wr(mk(1'b0, 2'd0, 2'd2, 2'd0));
    skip(4 * l0 - 1);
    chk("R4 down before zero", int'(level), 1);
    skip(1);
    chk("R4 reaches zero", int'(level), 0);
    skip(30);
    chk("R4 holds zero", int'(level), 0);

    wr(mk(1'b1, 2'd0, 2'd2, 2'd0));
    skip(255 * l0 - 1);
    chk("R3 before top", int'(level), 254);
    skip(1);
    chk("R3 reaches top", int'(level), 255);
    skip(50);
    chk("R3 holds top", int'(level), 255);

    wr(mk(1'b0, 2'd0, 2'd2, 2'd0));
    skip(10 * l0);
    chk("R4 ten steps down", int'(level), 245);
    wr(mk(1'b1, 2'd0, 2'd2, 2'd0));
    chk("R6 reversal no jump", int'(level), 245);
    skip(l0 - 1);
    chk("R6 reversal timer restart", int'(level), 245);
    skip(1);
    chk("R6 reversal first step", int'(level), 246);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule